// File: doc/BRIEF.md
# PCM Voice Codec Serial Port

This block moves voice samples between a parallel sample interface and a synchronous serial link made of a bit clock, a frame sync that marks each 8 kHz frame, one serial output line and one serial input line. All serial pins are oversampled by a fast system clock. In every frame the block shifts one transmit word out, most significant bit first, and assembles one receive word from the serial input. The serial output is driven low at every bit period outside the word slot.

The word format comes from a select pin. Held low, it selects A-law. Held high, it selects mu-law. Wired to the frame sync, it selects 16-bit linear. A-law and mu-law words are 8 bits wide. A second pin picks the slot position. The slot can start in the bit period that opens with the frame sync rising edge, or one bit period later. Two conditions power the port down: the power-down pin going low, or the bit clock stopping while low. A mute pin replaces the words in both directions with the silence code of the active format.

Transmit words arrive on a valid/ready stream into a one-entry holding register. `tx_ready` is high whenever that register is empty. A word is accepted in any cycle where `tx_valid` and `tx_ready` are both high. The holding register is emptied at each frame start. Received words leave on `rx_data` with a one-cycle `rx_valid` strobe. That output has no back-pressure: the consumer must take the word in the strobe cycle.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `dx_out` and `rx_valid` are 0, `tx_ready` is 1, `fmt_out` is 0 (A-law) and `pd_out` is 0.
- R2: When `align_sel` is 1, the transmit word is sent on `dx_out` most significant bit first, one bit per bit-clock period. The first bit occupies the period that opens with the frame sync rising edge. `dx_out` is 0 in every other period of the frame.
- R3: When `align_sel` is 0, the whole slot, both transmit and receive, starts one bit-clock period later than under R2.
- R4: `dr_in` is sampled on bit-clock falling edges within the slot, most significant bit first. The word appears right-aligned on `rx_data` with `rx_valid` high for exactly one cycle, and exactly once per active frame.
- R5: `fmt_sel` held low gives A-law (`fmt_out`=0). Held high, it gives mu-law (`fmt_out`=1). Both formats use 8-bit words taken from `tx_data[7:0]`.
- R6: `fmt_sel` toggling with the frame sync gives linear mode (`fmt_out`=2) with 16-bit words. Linear mode is taken at the third frame start after the toggling begins. Until then the pin level at frame start decides between R5's two formats.
- R7: `tx_ready` is 0 while a word is held. A held word stays unchanged until the next frame start, which uses it and sets `tx_ready` back to 1.
- R8: When no word is held at a frame start, that frame sends the silence code. The silence code is 0xD5 for A-law, 0xFF for mu-law and 0x0000 for linear.
- R9: While `mute_n` is 0, the transmitted word and the presented received word are both the silence code of the format.
- R10: While `pdn_n` is 0, `pd_out` is 1, `dx_out` is 0 and no `rx_valid` occurs. Normal frames resume at the first frame sync after `pdn_n` returns to 1.
- R11: A bit clock held low for more than `MAX_HALF_CYC`+32 system cycles sets `pd_out`. The frame whose sync coincides with the clock's return is skipped. The frame after it is normal.
- R12: `fmt_out` changes only at a frame sync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Serial bit clock |
| fs_in | input | 1 | Frame sync, one rising edge per frame |
| dr_in | input | 1 | Serial receive data |
| fmt_sel | input | 1 | Format select: low, high, or wired to frame sync |
| align_sel | input | 1 | Slot position select |
| mute_n | input | 1 | Active-low mute |
| pdn_n | input | 1 | Active-low power-down |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Holding register empty |
| dx_out | output | 1 | Serial transmit data |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| fmt_out | output | 2 | Detected format: 0 A-law, 1 mu-law, 2 linear |
| pd_out | output | 1 | Port is powered down |

## Verification
The bench targets the slot position in both alignment modes. A design off by one bit period would shift every bit, and the frame-wide comparison of `dx_out` would show it. It checks the two-frame latency of linear detection and the stability of `fmt_out` between frame syncs. A detector that switched on the first toggle, or in mid-frame, would report the wrong format at the sampled points. It drives frames with an empty holding register, with mute active and with power-down active. A design that sent a stale word, muted only one direction or strobed `rx_valid` while powered down would show a mismatch or an unexpected received word. It stops the bit clock just short of the limit and well past it. A stop detector that fired early or never fired would show the wrong `pd_out`, and a restart on the returning edge would produce an extra received word.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int WORD_W = 16;
  localparam int CMP_W  = 8;

  typedef enum logic [1:0] {
    FMT_ALAW   = 2'd0,
    FMT_MULAW  = 2'd1,
    FMT_LINEAR = 2'd2
  } pcm_fmt_e;

  function automatic logic [4:0] fmt_bits(pcm_fmt_e f);
    return (f == FMT_LINEAR) ? 5'(WORD_W) : 5'(CMP_W);
  endfunction

  function automatic logic [WORD_W-1:0] fmt_zero(pcm_fmt_e f);
    case (f)
      FMT_ALAW:  return 16'h00D5;
      FMT_MULAW: return 16'h00FF;
      default:   return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= din[i];
        s2 <= s1;
      end
    end
    assign dout[i] = s2;
  end
endmodule

// File: rtl/pcm_bclk_watch.sv
module pcm_bclk_watch #(
  parameter int MAX_HALF_CYC = 1954,
  parameter int MARGIN       = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_lvl,
  input  logic bclk_rise,
  output logic stopped
);
  localparam int LIMIT = MAX_HALF_CYC + MARGIN;
  localparam int CW    = $clog2(LIMIT + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      stopped <= 1'b0;
    end else begin
      if (bclk_lvl) low_cnt <= '0;
      else if (low_cnt != CW'(LIMIT + 1)) low_cnt <= low_cnt + 1'b1;
      if (bclk_rise) stopped <= 1'b0;
      else if (!bclk_lvl && low_cnt == CW'(LIMIT)) stopped <= 1'b1;
    end
  end

  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !bclk_rise) |=> stopped);
endmodule

// File: rtl/pcm_fmt_detect.sv
module pcm_fmt_detect
  import pcm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fs_rise,
  input  logic     fs_fall,
  input  logic     fmt_lvl,
  output pcm_fmt_e fmt_next,
  output pcm_fmt_e fmt_q
);
  logic       rise_val, fall_val, have_rise;
  logic [1:0] streak, streak_n;
  logic       lin_ev;

  always_comb begin
    lin_ev   = have_rise & rise_val & ~fall_val;
    streak_n = lin_ev ? ((streak == 2'd2) ? 2'd2 : streak + 2'd1) : 2'd0;
    if (streak_n == 2'd2) fmt_next = FMT_LINEAR;
    else if (fmt_lvl)     fmt_next = FMT_MULAW;
    else                  fmt_next = FMT_ALAW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_val  <= 1'b0;
      fall_val  <= 1'b0;
      have_rise <= 1'b0;
      streak    <= 2'd0;
      fmt_q     <= FMT_ALAW;
    end else begin
      if (fs_fall) fall_val <= fmt_lvl;
      if (fs_rise) begin
        rise_val  <= fmt_lvl;
        have_rise <= 1'b1;
        streak    <= streak_n;
        fmt_q     <= fmt_next;
      end
    end
  end

  // R12
  fmt_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rise |=> $stable(fmt_q));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_pkg::*;
#(
  parameter int MAX_HALF_CYC = 1954
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_in,
  input  logic        fs_in,
  input  logic        dr_in,
  input  logic        fmt_sel,
  input  logic        align_sel,
  input  logic        mute_n,
  input  logic        pdn_n,
  input  logic [15:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        dx_out,
  output logic [15:0] rx_data,
  output logic        rx_valid,
  output logic [1:0]  fmt_out,
  output logic        pd_out
);
  localparam int NPIN = 7;
  localparam logic [NPIN-1:0] PIN_RST = 7'b1100000;

  logic [NPIN-1:0] pin_s;
  logic bclk_s, fs_s, dr_s, fmt_s, align_s, mute_s, pdn_s;
  logic bclk_d, fs_d;
  logic bclk_rise, bclk_fall, fs_rise, fs_fall;
  logic stopped, pd, frame_start;
  pcm_fmt_e fmt_next, fmt_q, frame_fmt;

  pcm_pin_sync #(.W(NPIN), .RST_VAL(PIN_RST)) i_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({pdn_n, mute_n, align_sel, fmt_sel, dr_in, fs_in, bclk_in}),
    .dout(pin_s)
  );
  assign {pdn_s, mute_s, align_s, fmt_s, dr_s, fs_s, bclk_s} = pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      fs_d   <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      fs_d   <= fs_s;
    end
  end
  assign bclk_rise = bclk_s & ~bclk_d;
  assign bclk_fall = ~bclk_s & bclk_d;
  assign fs_rise   = fs_s & ~fs_d;
  assign fs_fall   = ~fs_s & fs_d;

  pcm_bclk_watch #(.MAX_HALF_CYC(MAX_HALF_CYC)) i_watch (
    .clk(clk), .rst_n(rst_n), .bclk_lvl(bclk_s), .bclk_rise(bclk_rise),
    .stopped(stopped)
  );

  pcm_fmt_detect i_fmt (
    .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .fs_fall(fs_fall),
    .fmt_lvl(fmt_s), .fmt_next(fmt_next), .fmt_q(fmt_q)
  );

  assign pd          = ~pdn_s | stopped;
  assign frame_start = fs_rise & ~pd;

  // transmit holding register (valid/ready)
  logic        hold_full;
  logic [15:0] hold_word;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_word <= '0;
    end else begin
      if (frame_start) hold_full <= 1'b0;
      if (tx_valid && tx_ready) begin
        hold_word <= tx_data;
        hold_full <= 1'b1;
      end
    end
  end
  assign tx_ready = ~hold_full;

  // word chosen at frame start, left-aligned
  logic [15:0] ld_word, ld_aligned;
  always_comb begin
    if (!mute_s || !hold_full) ld_word = fmt_zero(fmt_next);
    else if (fmt_next == FMT_LINEAR) ld_word = hold_word;
    else ld_word = {8'h00, hold_word[7:0]};
    ld_aligned = (fmt_next == FMT_LINEAR) ? ld_word : {ld_word[7:0], 8'h00};
  end

  logic [15:0] tx_sh;
  logic [4:0]  tx_left, rx_cnt, cur_w;
  logic        pending, tx_act, rx_act, dx_q;
  logic [14:0] rx_sh;
  logic [15:0] rx_new, rx_mask;

  assign cur_w   = fmt_bits(frame_fmt);
  assign rx_new  = {rx_sh, dr_s};
  assign rx_mask = (frame_fmt == FMT_LINEAR) ? 16'hFFFF : 16'h00FF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      tx_left   <= '0;
      pending   <= 1'b0;
      tx_act    <= 1'b0;
      rx_act    <= 1'b0;
      rx_cnt    <= '0;
      rx_sh     <= '0;
      dx_q      <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_fmt <= FMT_ALAW;
    end else if (pd) begin
      pending  <= 1'b0;
      tx_act   <= 1'b0;
      rx_act   <= 1'b0;
      dx_q     <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (frame_start) begin
        frame_fmt <= fmt_next;
        tx_sh     <= ld_aligned;
        if (align_s) begin
          pending <= 1'b0;
          tx_act  <= 1'b1;
          dx_q    <= ld_aligned[15];
          tx_left <= fmt_bits(fmt_next) - 5'd1;
          rx_act  <= 1'b1;
          rx_cnt  <= '0;
        end else begin
          pending <= 1'b1;
          tx_act  <= 1'b0;
          dx_q    <= 1'b0;
          rx_act  <= 1'b0;
        end
      end else if (bclk_rise) begin
        if (pending) begin
          pending <= 1'b0;
          tx_act  <= 1'b1;
          dx_q    <= tx_sh[15];
          tx_left <= cur_w - 5'd1;
          rx_act  <= 1'b1;
          rx_cnt  <= '0;
        end else if (tx_act) begin
          if (tx_left == 5'd0) begin
            tx_act <= 1'b0;
            dx_q   <= 1'b0;
          end else begin
            tx_sh   <= {tx_sh[14:0], 1'b0};
            dx_q    <= tx_sh[14];
            tx_left <= tx_left - 5'd1;
          end
        end
      end
      if (bclk_fall && rx_act) begin
        rx_sh  <= rx_new[14:0];
        rx_cnt <= rx_cnt + 5'd1;
        if (rx_cnt == cur_w - 5'd1) begin
          rx_act   <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= mute_s ? (rx_new & rx_mask) : fmt_zero(frame_fmt);
        end
      end
    end
  end

  assign dx_out  = dx_q;
  assign fmt_out = fmt_q;
  assign pd_out  = pd;

  // R4
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!dx_out && !rx_valid));
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !frame_start) |=> (hold_full && $stable(hold_word)));
  // R2
  slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_act |-> (tx_left < cur_w));
endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
  localparam int H  = 8;
  localparam int N  = 3;
  localparam int FP = 8 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_i = 0, fs_i = 0, dr_i = 0, fmt_i = 0, align_i = 1, mute_i = 1, pdn_i = 1;
  logic [15:0] tx_data = '0;
  logic tx_valid = 0;
  logic tx_ready, dx_out, rx_valid, pd_out;
  logic [15:0] rx_data;
  logic [1:0] fmt_out;

  int checks = 0, errors = 0;
  int fmt_mode = 0;   // 0 low, 1 high, 2 follows frame sync
  int bw = 8;         // expected word width
  int bfmt = 0;       // expected format code
  bit done = 0;
  logic [16:0] rxq[$];

  always #2 clk = ~clk;

  pcm_serial_port #(.MAX_HALF_CYC(24)) i_pcm_serial_port (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_i), .fs_in(fs_i), .dr_in(dr_i),
    .fmt_sel(fmt_i), .align_sel(align_i), .mute_n(mute_i), .pdn_n(pdn_i),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .dx_out(dx_out), .rx_data(rx_data), .rx_valid(rx_valid),
    .fmt_out(fmt_out), .pd_out(pd_out)
  );

  function automatic logic [15:0] zero_of(int f);
    return (f == 0) ? 16'h00D5 : (f == 1) ? 16'h00FF : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pop expected received words
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) begin
        check(0, "R10 unexpected rx_valid", {16'h0, rx_data}, 32'h0);
      end else begin
        logic [16:0] e;
        e = rxq.pop_front();
        if (e[16]) check(rx_data == e[15:0], "R4 rx word", {16'h0, rx_data}, {16'h0, e[15:0]});
      end
    end
  end

  task automatic send_word(input logic [15:0] w);
    while (!tx_ready) @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [15:0] txw, input logic [15:0] rxw,
                           input bit chk_tx, input bit exp_rx, input bit chk_rx,
                           input string tag);
    int off;
    logic [23:0] got, expf;
    logic [15:0] rexp;
    off  = align_i ? 0 : 1;
    expf = '0;
    for (int p = 0; p < FP; p++) begin
      int idx = p - off;
      if (idx >= 0 && idx < bw) expf[p] = txw[bw-1-idx];
    end
    if (exp_rx) begin
      rexp = !mute_i ? zero_of(bfmt) : ((bw == 16) ? rxw : {8'h00, rxw[7:0]});
      rxq.push_back({chk_rx, rexp});
    end
    for (int p = 0; p < FP; p++) begin
      int idx = p - off;
      bclk_i = 1'b1;
      fs_i   = (p == 0);
      if (fmt_mode == 2) fmt_i = (p == 0);
      dr_i   = (idx >= 0 && idx < bw) ? rxw[bw-1-idx] : 1'b1;
      repeat (H) @(negedge clk);
      bclk_i = 1'b0;
      repeat (H - 1) @(negedge clk);
      got[p] = dx_out;
      @(negedge clk);
    end
    if (chk_tx) check(got == expf, tag, {8'h0, got}, {8'h0, expf});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(dx_out == 0 && rx_valid == 0, "R1 outputs idle", {30'h0, dx_out, rx_valid}, 32'h0);
    check(tx_ready == 1 && fmt_out == 0 && pd_out == 0, "R1 ready/fmt/pd",
          {28'h0, tx_ready, fmt_out, pd_out}, {28'h0, 1'b1, 2'd0, 1'b0});

    // R2 R5 A-law, slot opens at frame sync
    fmt_mode = 0; fmt_i = 0; bw = 8; bfmt = 0; align_i = 1;
    send_word(16'h003C);
    repeat (2) @(negedge clk);
    check(tx_ready == 0, "R7 ready low while held", {31'h0, tx_ready}, 32'h0);
    run_frame(16'h003C, 16'h00A5, 1, 1, 1, "R2 A-law aligned tx");
    check(fmt_out == 0, "R5 A-law code", {30'h0, fmt_out}, 32'h0);
    check(tx_ready == 1, "R7 ready after frame start", {31'h0, tx_ready}, 32'h1);
    // R8 underrun
    run_frame(16'h00D5, 16'h005A, 1, 1, 1, "R8 A-law silence");

    // R5 mu-law
    fmt_mode = 1; fmt_i = 1; bfmt = 1;
    send_word(16'h0081);
    run_frame(16'h0081, 16'h007E, 1, 1, 1, "R5 mu-law tx");
    check(fmt_out == 1, "R5 mu-law code", {30'h0, fmt_out}, 32'h1);
    run_frame(16'h00FF, 16'h0011, 1, 1, 1, "R8 mu-law silence");

    // R3 delayed slot
    align_i = 0;
    repeat (4) @(negedge clk);
    send_word(16'h00C3);
    run_frame(16'h00C3, 16'h0096, 1, 1, 1, "R3 delayed slot tx");

    // R9 mute
    mute_i = 0;
    repeat (4) @(negedge clk);
    send_word(16'h0012);
    run_frame(16'h00FF, 16'h0034, 1, 1, 1, "R9 mute mu-law tx");
    mute_i = 1;
    repeat (4) @(negedge clk);

    // R6 linear detection
    fmt_mode = 2;
    send_word(16'h0055);
    run_frame(16'h0055, 16'h0022, 0, 1, 0, "warm1");
    send_word(16'h0066);
    run_frame(16'h0066, 16'h0033, 0, 1, 0, "warm2");
    check(fmt_out == 1, "R6 not linear before third frame", {30'h0, fmt_out}, 32'h1);
    bw = 16; bfmt = 2;
    send_word(16'hBEEF);
    run_frame(16'hBEEF, 16'h1357, 1, 1, 1, "R6 linear delayed tx");
    check(fmt_out == 2, "R6 linear code", {30'h0, fmt_out}, 32'h2);
    align_i = 1;
    repeat (4) @(negedge clk);
    send_word(16'h8001);
    run_frame(16'h8001, 16'hF00F, 1, 1, 1, "R6 linear aligned tx");
    run_frame(16'h0000, 16'h4242, 1, 1, 1, "R8 linear silence");
    mute_i = 0;
    repeat (4) @(negedge clk);
    send_word(16'h7777);
    run_frame(16'h0000, 16'h9999, 1, 1, 1, "R9 mute linear tx");
    mute_i = 1;

    // R12 format steady between syncs
    fmt_mode = 0; fmt_i = 0;
    repeat (20) @(negedge clk);
    check(fmt_out == 2, "R12 fmt steady mid-frame", {30'h0, fmt_out}, 32'h2);
    run_frame(16'h0000, 16'h0000, 0, 1, 0, "tail");
    bw = 8; bfmt = 0;
    send_word(16'h0024);
    run_frame(16'h0024, 16'h00E7, 1, 1, 1, "R5 back to A-law tx");
    check(fmt_out == 0, "R12 fmt updated at sync", {30'h0, fmt_out}, 32'h0);

    // R10 power-down pin
    pdn_i = 0;
    repeat (5) @(negedge clk);
    check(pd_out == 1, "R10 pd_out set", {31'h0, pd_out}, 32'h1);
    run_frame(16'h0000, 16'h00AA, 1, 0, 0, "R10 dx low in power-down");
    pdn_i = 1;
    repeat (5) @(negedge clk);
    check(pd_out == 0, "R10 pd_out clear", {31'h0, pd_out}, 32'h0);
    send_word(16'h0066);
    run_frame(16'h0066, 16'h0099, 1, 1, 1, "R10 resume tx");

    // R11 bit clock stop
    repeat (40) @(negedge clk);
    check(pd_out == 0, "R11 no stop below limit", {31'h0, pd_out}, 32'h0);
    repeat (60) @(negedge clk);
    check(pd_out == 1, "R11 stop detected", {31'h0, pd_out}, 32'h1);
    run_frame(16'h0000, 16'h00C0, 1, 0, 0, "R11 skipped frame dx low");
    check(pd_out == 0, "R11 clock back", {31'h0, pd_out}, 32'h0);
    send_word(16'h000F);
    run_frame(16'h000F, 16'h00F0, 1, 1, 1, "R11 resume tx");

    repeat (10) @(negedge clk);
    check(rxq.size() == 0, "R4 one word per frame", rxq.size(), 32'h0);
    finish_run();
  end
endmodule